// File: doc/BRIEF.md
# Guest TLB invalidation unit

This block services invalidate requests aimed at guest-stage (VS-stage) address translations and applies them to a small, fully associative TLB that it holds. A request carries the raw instruction word, the two source register values, the privilege level, the virtualization flag and the hypervisor-enable bit. The block pulls both register indices out of the instruction word and checks whether the request is allowed. It then either raises one of two exception flags, or builds a match filter and drops every valid entry the filter selects.

The filter always scopes the request to the VMID currently held in the guest-translation control register, which arrives on `guest_vmid`. Which fields take part in the match depends only on whether each register index is zero, never on the register contents. A narrow fill port loads entries, because refilling from page-table walks is handled elsewhere. Completion is reported by a one-cycle `done` pulse, one cycle after the request is accepted.

Top module: `gtinv_unit`

## Requirements
- R1: The first register index is instruction bits 19:15 and the second is bits 24:20. The scope is selected by whether each index is zero, so a nonzero index whose register value is zero still selects its field. Only ASID_W=16 low bits of the second value are used.
- R2: A request with `req_prv`=00 (user) and `req_virt`=0 sets `exc_illegal` with `done` and leaves every entry unchanged.
- R3: A request with `req_virt`=1 while `hyp_en`=1, whether `req_prv` is 01 or 00, sets `exc_virtual` with `done` and leaves every entry unchanged.
- R4: Requests with `req_prv`=11 (machine) or `req_prv`=01 with `req_virt`=0 raise no exception.
- R5: Only entries whose VMID tag equals `guest_vmid` can be invalidated.
- R6: With both indices zero, every valid entry of the current VMID is cleared, global ones included.
- R7: With only the first index zero, entries whose ASID equals the low 16 bits of the second value are cleared, except entries marked global.
- R8: With only the second index zero, entries whose page number equals first-value bits 38:12 are cleared, global ones included.
- R9: With both indices nonzero, an entry is cleared only if it matches both the ASID and the page number and is not global.
- R10: In either address form, if bits 63:39 of the first value are not all equal to bit 38, nothing is cleared and no exception is raised. `done` still pulses.
- R11: A request is accepted on an edge where `req_valid` and `req_ready` are both high. `req_ready` is low while `fill_we` is high and in the `done` cycle. `done` is high for exactly the one cycle after acceptance, and the entry changes are visible in that same cycle.
- R12: `fill_we` writes the VMID, ASID, page number and global tags at `fill_idx` and marks that entry valid on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all entries |
| fill_we | input | 1 | Entry write strobe |
| fill_idx | input | 3 | Entry slot to write |
| fill_vmid | input | 14 | VMID tag to write |
| fill_asid | input | 16 | ASID tag to write |
| fill_vpn | input | 27 | Virtual page number to write |
| fill_global | input | 1 | Global flag to write |
| req_valid | input | 1 | Invalidate request present |
| req_ready | output | 1 | Block can accept a request |
| req_insn | input | 32 | Instruction word of the request |
| req_rs1_val | input | 64 | First source register value (address) |
| req_rs2_val | input | 64 | Second source register value (ASID) |
| req_prv | input | 2 | Privilege: 00 user, 01 supervisor, 11 machine |
| req_virt | input | 1 | Request issued from a virtualized mode |
| hyp_en | input | 1 | Hypervisor extension enabled |
| guest_vmid | input | 14 | VMID field of the guest-translation control register |
| done | output | 1 | One-cycle completion pulse |
| exc_illegal | output | 1 | Illegal-instruction outcome, valid with done |
| exc_virtual | output | 1 | Virtual-instruction outcome, valid with done |
| entry_valid | output | 8 | Valid bit of each TLB entry |

## Verification
The assertions assume that a virtualized request never arrives while the hypervisor is disabled, and that `req_prv` never carries the reserved code 10. They also assume fill and request traffic are kept apart by `req_ready`. The stimulus only uses legal privilege codes and only sets `req_virt` with `hyp_en` high. It starts a fill only after the previous `done` cycle has passed, so the checks on `entry_valid` around `done` see only the effect of the invalidation.

// File: rtl/gtinv_pkg.sv
package gtinv_pkg;

   typedef enum logic [1:0] {
      PRV_USER  = 2'b00,
      PRV_SUPER = 2'b01,
      PRV_MACH  = 2'b11
   } prv_e;

   typedef enum logic [1:0] {
      OUT_NONE    = 2'd0,
      OUT_ILLEGAL = 2'd1,
      OUT_VIRTUAL = 2'd2
   } outcome_e;

   typedef struct packed {
      logic apply;     // filter is live
      logic by_asid;   // compare ASID, spare global entries
      logic by_page;   // compare page number
   } scope_t;

endpackage

// File: rtl/gtinv_decode.sv
module gtinv_decode
   import gtinv_pkg::*;
#(
   parameter int XLEN       = 64,
   parameter int VA_BITS    = 39,
   parameter int ASID_W     = 16,
   parameter int PAGE_SHIFT = 12
) (
   input  logic [31:0]                  insn,
   input  logic [XLEN-1:0]              rs1_val,
   input  logic [XLEN-1:0]              rs2_val,
   input  logic [1:0]                   prv,
   input  logic                         virt,
   input  logic                         hyp_en,
   output outcome_e                     outcome,
   output scope_t                       scope,
   output logic [ASID_W-1:0]            key_asid,
   output logic [VA_BITS-1:PAGE_SHIFT]  key_page
);
   localparam int IDX_LO1 = 15;
   localparam int IDX_LO2 = 20;

   logic [4:0] src1_idx, src2_idx;
   logic       canon;
   logic [XLEN-1:VA_BITS-1] va_top;
   logic       unused_bits;

   assign src1_idx = insn[IDX_LO1 +: 5];
   assign src2_idx = insn[IDX_LO2 +: 5];
   assign va_top   = rs1_val[XLEN-1:VA_BITS-1];
   assign canon    = (&va_top) | ~(|va_top);
   assign key_asid = rs2_val[ASID_W-1:0];
   assign key_page = rs1_val[VA_BITS-1:PAGE_SHIFT];
   assign unused_bits = ^{insn[31:25], insn[14:0], rs1_val[PAGE_SHIFT-1:0],
                          rs2_val[XLEN-1:ASID_W]};

   always_comb begin
      if (prv_e'(prv) == PRV_USER && !virt)
         outcome = OUT_ILLEGAL;
      else if (hyp_en && virt)
         outcome = OUT_VIRTUAL;
      else
         outcome = OUT_NONE;
   end

   always_comb begin
      scope.by_page = (src1_idx != 5'd0);
      scope.by_asid = (src2_idx != 5'd0);
      scope.apply   = (outcome == OUT_NONE) && (!scope.by_page || canon);
   end

endmodule

// File: rtl/gtinv_match.sv
module gtinv_match
   import gtinv_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int VMID_W  = 14,
   parameter int ASID_W  = 16,
   parameter int VPN_W   = 27
) (
   input  logic [ENTRIES-1:0] ent_valid,
   input  logic [ENTRIES-1:0] ent_global,
   input  logic [VMID_W-1:0]  ent_vmid [ENTRIES],
   input  logic [ASID_W-1:0]  ent_asid [ENTRIES],
   input  logic [VPN_W-1:0]   ent_vpn  [ENTRIES],
   input  logic [VMID_W-1:0]  cur_vmid,
   input  scope_t             scope,
   input  logic [ASID_W-1:0]  key_asid,
   input  logic [VPN_W-1:0]   key_page,
   output logic [ENTRIES-1:0] kill
);
   for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      logic vmid_hit, asid_ok, page_ok;
      assign vmid_hit = ent_vmid[g] == cur_vmid;
      assign asid_ok  = !scope.by_asid || (ent_asid[g] == key_asid && !ent_global[g]);
      assign page_ok  = !scope.by_page || (ent_vpn[g] == key_page);
      assign kill[g]  = scope.apply && ent_valid[g] && vmid_hit && asid_ok && page_ok;
   end
endmodule

// File: rtl/gtinv_unit.sv
module gtinv_unit
   import gtinv_pkg::*;
#(
   parameter int XLEN       = 64,
   parameter int VA_BITS    = 39,
   parameter int PAGE_SHIFT = 12,
   parameter int ASID_W     = 16,
   parameter int VMID_W     = 14,
   parameter int ENTRIES    = 8,
   localparam int IDX_W     = $clog2(ENTRIES),
   localparam int VPN_W     = VA_BITS - PAGE_SHIFT
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fill_we,
   input  logic [IDX_W-1:0]   fill_idx,
   input  logic [VMID_W-1:0]  fill_vmid,
   input  logic [ASID_W-1:0]  fill_asid,
   input  logic [VPN_W-1:0]   fill_vpn,
   input  logic               fill_global,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [31:0]        req_insn,
   input  logic [XLEN-1:0]    req_rs1_val,
   input  logic [XLEN-1:0]    req_rs2_val,
   input  logic [1:0]         req_prv,
   input  logic               req_virt,
   input  logic               hyp_en,
   input  logic [VMID_W-1:0]  guest_vmid,
   output logic               done,
   output logic               exc_illegal,
   output logic               exc_virtual,
   output logic [ENTRIES-1:0] entry_valid
);
   if (ENTRIES < 2)               begin : g_bad_entries $error("ENTRIES must be at least 2"); end
   if (VA_BITS >= XLEN)           begin : g_bad_va      $error("VA_BITS must be below XLEN"); end
   if (PAGE_SHIFT >= VA_BITS)     begin : g_bad_page    $error("PAGE_SHIFT must be below VA_BITS"); end
   if (ASID_W > XLEN || VMID_W < 1) begin : g_bad_tags  $error("tag widths out of range"); end

   logic [ENTRIES-1:0] valid_q, glob_q, kill;
   logic [VMID_W-1:0]  vmid_q [ENTRIES];
   logic [ASID_W-1:0]  asid_q [ENTRIES];
   logic [VPN_W-1:0]   vpn_q  [ENTRIES];

   outcome_e            outcome;
   scope_t              scope;
   logic [ASID_W-1:0]   key_asid;
   logic [VPN_W-1:0]    key_page;
   logic                accept;

   assign req_ready   = !done && !fill_we;
   assign accept      = req_valid && req_ready;
   assign entry_valid = valid_q;

   gtinv_decode #(
      .XLEN(XLEN), .VA_BITS(VA_BITS), .ASID_W(ASID_W), .PAGE_SHIFT(PAGE_SHIFT)
   ) u_decode (
      .insn(req_insn), .rs1_val(req_rs1_val), .rs2_val(req_rs2_val),
      .prv(req_prv), .virt(req_virt), .hyp_en(hyp_en),
      .outcome(outcome), .scope(scope), .key_asid(key_asid), .key_page(key_page)
   );

   gtinv_match #(
      .ENTRIES(ENTRIES), .VMID_W(VMID_W), .ASID_W(ASID_W), .VPN_W(VPN_W)
   ) u_match (
      .ent_valid(valid_q), .ent_global(glob_q), .ent_vmid(vmid_q),
      .ent_asid(asid_q), .ent_vpn(vpn_q), .cur_vmid(guest_vmid),
      .scope(scope), .key_asid(key_asid), .key_page(key_page), .kill(kill)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q     <= '0;
         done        <= 1'b0;
         exc_illegal <= 1'b0;
         exc_virtual <= 1'b0;
      end else begin
         done        <= accept;
         exc_illegal <= accept && (outcome == OUT_ILLEGAL);
         exc_virtual <= accept && (outcome == OUT_VIRTUAL);
         if (fill_we)
            valid_q[fill_idx] <= 1'b1;
         else if (accept)
            valid_q <= valid_q & ~kill;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_we) begin
         glob_q[fill_idx] <= fill_global;
         vmid_q[fill_idx] <= fill_vmid;
         asid_q[fill_idx] <= fill_asid;
         vpn_q[fill_idx]  <= fill_vpn;
      end
   end

   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R11
   done_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(req_valid && req_ready));

   // R11
   exc_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_illegal || exc_virtual) |-> done);

   // R2
   exc_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({exc_illegal, exc_virtual}));

   // R3
   exc_keeps_entries_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_illegal || exc_virtual) |-> entry_valid == $past(entry_valid));

   // R6
   inval_only_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (entry_valid & ~$past(entry_valid)) == '0);

endmodule

// File: tb/gtinv_unit_bench.sv
module gtinv_unit_bench;
   localparam time CLK_PERIOD = 10ns;
   localparam int  N = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fill_we = 1'b0;
   logic [2:0]  fill_idx = '0;
   logic [13:0] fill_vmid = '0;
   logic [15:0] fill_asid = '0;
   logic [26:0] fill_vpn = '0;
   logic        fill_global = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_insn = '0;
   logic [63:0] req_rs1_val = '0;
   logic [63:0] req_rs2_val = '0;
   logic [1:0]  req_prv = 2'b11;
   logic        req_virt = 1'b0;
   logic        hyp_en = 1'b1;
   logic [13:0] guest_vmid = 14'h05;
   logic        done, exc_illegal, exc_virtual;
   logic [N-1:0] entry_valid;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   typedef struct {
      logic [N-1:0] valid;
      logic         ill;
      logic         virt;
      string        req;
   } exp_t;
   exp_t sb[$];

   logic [N-1:0] m_valid = '0;
   logic [N-1:0] m_glob;
   logic [13:0]  m_vmid [N];
   logic [15:0]  m_asid [N];
   logic [26:0]  m_vpn  [N];

   always #(CLK_PERIOD/2) clk = ~clk;

   gtinv_unit u_gtinv_unit (
      .clk(clk), .rst_n(rst_n), .fill_we(fill_we), .fill_idx(fill_idx),
      .fill_vmid(fill_vmid), .fill_asid(fill_asid), .fill_vpn(fill_vpn),
      .fill_global(fill_global), .req_valid(req_valid), .req_ready(req_ready),
      .req_insn(req_insn), .req_rs1_val(req_rs1_val), .req_rs2_val(req_rs2_val),
      .req_prv(req_prv), .req_virt(req_virt), .hyp_en(hyp_en),
      .guest_vmid(guest_vmid), .done(done), .exc_illegal(exc_illegal),
      .exc_virtual(exc_virtual), .entry_valid(entry_valid)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // monitor: pops the scoreboard on every done pulse
   logic prev_done = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (done && prev_done)
            check(0, "R11", "done held two cycles", 1, 0);
         if (done) begin
            check(!req_ready, "R11", "ready during done", req_ready, 0);
            if (sb.size() == 0) begin
               check(0, "R11", "unexpected done", 1, 0);
            end else begin
               exp_t e;
               e = sb.pop_front();
               check(entry_valid == e.valid, e.req, "entry_valid", entry_valid, e.valid);
               check(exc_illegal == e.ill, e.req, "exc_illegal", exc_illegal, e.ill);
               check(exc_virtual == e.virt, e.req, "exc_virtual", exc_virtual, e.virt);
            end
         end
      end
      prev_done = done;
   end

   task automatic put_entry(input int i, input logic [13:0] vm, input logic [15:0] as,
                            input logic [26:0] vp, input logic g);
      fill_we = 1'b1; fill_idx = 3'(i); fill_vmid = vm; fill_asid = as;
      fill_vpn = vp; fill_global = g;
      m_valid[i] = 1'b1; m_vmid[i] = vm; m_asid[i] = as; m_vpn[i] = vp; m_glob[i] = g;
   endtask

   // R12: load the fixed entry set
   task automatic fill_all();
      @(negedge clk); put_entry(0, 14'h05, 16'h0011, 27'h100, 1'b0);
      #1 check(!req_ready, "R11", "ready during fill", req_ready, 0);
      @(negedge clk); put_entry(1, 14'h05, 16'h0011, 27'h200, 1'b1);
      @(negedge clk); put_entry(2, 14'h05, 16'h0022, 27'h100, 1'b0);
      @(negedge clk); put_entry(3, 14'h05, 16'h0022, 27'h000, 1'b0);
      @(negedge clk); put_entry(4, 14'h2A, 16'h0011, 27'h100, 1'b0);
      @(negedge clk); put_entry(5, 14'h05, 16'h0033, 27'h7FFFFFF, 1'b0);
      @(negedge clk); put_entry(6, 14'h05, 16'h0011, 27'h300, 1'b0);
      @(negedge clk); put_entry(7, 14'h05, 16'h0044, 27'h200, 1'b1);
      @(negedge clk); fill_we = 1'b0;
      check(entry_valid == {N{1'b1}}, "R12", "entries after fill", entry_valid, {N{1'b1}});
   endtask

   // driver: models the expected outcome, pushes it, then issues the request
   task automatic inval(input string req, input logic [4:0] i1, input logic [4:0] i2,
                        input logic [63:0] v1, input logic [63:0] v2,
                        input logic [1:0] prv, input logic virt);
      exp_t e;
      logic ill, vir, canon;
      ill   = (prv == 2'b00) && !virt;
      vir   = !ill && hyp_en && virt;
      canon = (v1[63:38] == '0) || (v1[63:38] == '1);
      if (!ill && !vir) begin
         for (int i = 0; i < N; i++) begin
            logic hit;
            hit = m_valid[i] && (m_vmid[i] == guest_vmid);
            if (i2 != 0) hit = hit && (m_asid[i] == v2[15:0]) && !m_glob[i];
            if (i1 != 0) hit = hit && (m_vpn[i] == v1[38:12]) && canon;
            if (hit) m_valid[i] = 1'b0;
         end
      end
      e.valid = m_valid; e.ill = ill; e.virt = vir; e.req = req;
      sb.push_back(e);
      @(negedge clk);
      req_valid = 1'b1; req_prv = prv; req_virt = virt;
      req_insn = {7'b0010011, i2, i1, 3'b000, 5'b00000, 7'b1110011};
      req_rs1_val = v1; req_rs2_val = v2;
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         failures++; checks++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(entry_valid == '0, "R12", "reset entries", entry_valid, 0);
      check(!done && !exc_illegal && !exc_virtual, "R11", "reset outputs",
            {done, exc_illegal, exc_virtual}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready, "R11", "ready after reset", req_ready, 1);

      fill_all();
      inval("R2",  5'd0, 5'd0, 64'h0, 64'h0, 2'b00, 1'b0);           // user
      inval("R3",  5'd0, 5'd0, 64'h0, 64'h0, 2'b01, 1'b1);           // VS
      inval("R3",  5'd2, 5'd0, 64'h100000, 64'h0, 2'b00, 1'b1);      // VU
      inval("R7",  5'd0, 5'd5, 64'h0, 64'hDEAD_0011, 2'b01, 1'b0);   // ASID only, upper bits ignored
      inval("R8",  5'd7, 5'd0, 64'h200123, 64'h0, 2'b11, 1'b0);      // page only, machine (R4)

      fill_all();
      inval("R10", 5'd6, 5'd0, 64'h0000_0080_0010_0000, 64'h0, 2'b01, 1'b0);
      inval("R9",  5'd3, 5'd4, 64'h100000, 64'h22, 2'b01, 1'b0);
      inval("R1",  5'd9, 5'd0, 64'h0, 64'h0, 2'b11, 1'b0);           // index set, value zero
      inval("R10", 5'd8, 5'd0, 64'hFFFF_FFFF_FFFF_F000, 64'h0, 2'b01, 1'b0);
      inval("R9",  5'd1, 5'd1, 64'h200000, 64'h11, 2'b11, 1'b0);     // global survives

      fill_all();
      inval("R6",  5'd0, 5'd0, 64'h0, 64'h0, 2'b01, 1'b0);           // leaves VMID 0x2A
      fill_all();
      guest_vmid = 14'h2A;
      inval("R5",  5'd0, 5'd0, 64'h0, 64'h0, 2'b11, 1'b0);           // only the other VMID
      guest_vmid = 14'h05;

      repeat (3) @(negedge clk);
      check(sb.size() == 0, "R11", "missing done pulses", sb.size(), 0);
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule